// File: doc/BRIEF.md
# Link Synchronization Controller

This block decides whether a 16-bit 8b/10b receive link can be trusted. A decoder upstream classifies each received word. It raises exactly one of five class strobes: idle, carrier extend, data, error propagation, or invalid code group. The controller steps through three states from those strobes: acquiring, synchronized, and checking. It reports link status, enables the comma aligner only while acquiring, and qualifies received words for the downstream consumer.

Entry to the synchronized state is asymmetric. A run of fill words (idle or carrier extend) is needed, but a single payload word (data or error propagation) is enough. A single bad word moves the link into a checking state, and link status stays up there. A run of good words returns the link to synchronized. A tally of bad words, which need not be consecutive, drops the link back to acquisition. All outputs are registered, and reset is synchronous and active high. Each class strobe is sampled once per rising clock edge.

Top module: `link_sync_ctrl`

## Requirements
- R1: After a clock edge with `rst` high, whatever the class inputs are, the controller is acquiring. The outputs are `link_up`=0, `align_en`=1, `rx_valid`=0 and `sync_lost`=0.
- R2: While acquiring, ACQ_RUN (default 3) consecutive fill words take the controller to synchronized, and `link_up` rises after the edge that sampled the last of them. Fill words are idle or carrier extend, in any mix.
- R3: While acquiring, one data or error-propagation word takes the controller to synchronized, and `link_up` rises after that edge.
- R4: While acquiring, an invalid word restarts the fill-word run from zero.
- R5: While synchronized, one invalid word moves the controller to checking. `link_up` stays 1 and `align_en` stays 0.
- R6: While checking, CHK_GOOD (default 4) consecutive valid words return the controller to synchronized. From there, three further invalid words do not drop the link.
- R7: While checking, an invalid word restarts the good-word run but keeps the bad-word tally. The word that caused entry to checking is not counted. Valid words never clear the tally. The tally reaching CHK_BAD (default 3) moves the controller to acquiring.
- R8: On each move into acquiring, `sync_lost` is 1 for exactly one cycle, together with `link_up`=0 and `align_en`=1.
- R9: `rx_valid` is 1 for one cycle after a valid word whose evaluation leaves the controller synchronized or checking. It is 0 after invalid words and after fill words that do not complete the acquisition run.
- R10: A word with more than one class input asserted is treated as an invalid word.
- R11: A cycle with no class input asserted carries no word. State and counters hold, an acquisition run in progress is not broken, and `rx_valid` and `sync_lost` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| word_idle | input | 1 | Current word is a valid idle |
| word_cext | input | 1 | Current word is a valid carrier extend |
| word_data | input | 1 | Current word is valid data |
| word_eprop | input | 1 | Current word is an error-propagation code |
| word_bad | input | 1 | Current word is an invalid code group |
| link_up | output | 1 | Link synchronized (synchronized or checking) |
| align_en | output | 1 | Comma realignment permitted (acquiring only) |
| rx_valid | output | 1 | Previous word is qualified for use |
| sync_lost | output | 1 | One-cycle pulse on entry to acquiring |

## Verification
Being in checking while the design thinks it is synchronized is invisible at the ports for the moment, because `link_up` is 1 in both states. The difference shows only later, in how many invalid words it takes to drop the link: three while checking, four from synchronized. The sequences therefore follow each recovery with a string of bad words. A fill or good-word counter that misses a clear shows up as `link_up` changing one or more words early. That happens within the few words of the run being tested, so every stimulus word is followed by a check of all four outputs one edge later.

// File: rtl/lnk_sync_pkg.sv
package lnk_sync_pkg;

  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_SYNC  = 2'd1,
    ST_CHECK = 2'd2
  } lnk_state_t;

  typedef enum logic [1:0] {
    WK_NONE    = 2'd0,
    WK_FILL    = 2'd1,
    WK_PAYLOAD = 2'd2,
    WK_BAD     = 2'd3
  } word_kind_t;

  localparam int N_CLS     = 5;
  localparam int CLS_IDLE  = 0;
  localparam int CLS_CEXT  = 1;
  localparam int CLS_DATA  = 2;
  localparam int CLS_EPROP = 3;
  localparam int CLS_BAD   = 4;

endpackage

// File: rtl/lnk_word_class.sv
module lnk_word_class
  import lnk_sync_pkg::*;
(
  input  logic [N_CLS-1:0] cls_vec,
  output word_kind_t       kind
);

  always_comb begin
    if (cls_vec == '0)
      kind = WK_NONE;
    else if ($countones(cls_vec) > 1)
      kind = WK_BAD;          // R10: ambiguous word counts as invalid
    else if (cls_vec[CLS_BAD])
      kind = WK_BAD;
    else if (cls_vec[CLS_IDLE] || cls_vec[CLS_CEXT])
      kind = WK_FILL;
    else
      kind = WK_PAYLOAD;
  end

endmodule

// File: rtl/lnk_run_cnt.sv
module lnk_run_cnt #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_last
);

  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc)
      count <= count + W'(1);
  end

  assign at_last = (count == W'(LIMIT - 1));

  // R7: the controller clears a run before it could reach its limit
  a_r7_run_below_limit: assert property (@(posedge clk) disable iff (rst)
    count < W'(LIMIT));

endmodule

// File: rtl/link_sync_ctrl.sv
module link_sync_ctrl
  import lnk_sync_pkg::*;
#(
  parameter int ACQ_RUN  = 3,
  parameter int CHK_GOOD = 4,
  parameter int CHK_BAD  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic word_idle,
  input  logic word_cext,
  input  logic word_data,
  input  logic word_eprop,
  input  logic word_bad,
  output logic link_up,
  output logic align_en,
  output logic rx_valid,
  output logic sync_lost
);

  logic [N_CLS-1:0] cls_vec;
  word_kind_t       kind;
  lnk_state_t       st, nxt;
  logic             good, bad;
  logic             fill_inc, fill_clr, fill_last;
  logic             ok_inc, ok_clr, ok_last;
  logic             err_inc, err_clr, err_last;

  always_comb begin
    cls_vec            = '0;
    cls_vec[CLS_IDLE]  = word_idle;
    cls_vec[CLS_CEXT]  = word_cext;
    cls_vec[CLS_DATA]  = word_data;
    cls_vec[CLS_EPROP] = word_eprop;
    cls_vec[CLS_BAD]   = word_bad;
  end

  lnk_word_class i_class (
    .cls_vec (cls_vec),
    .kind    (kind)
  );

  lnk_run_cnt #(.LIMIT(ACQ_RUN)) i_fill_run (
    .clk (clk), .rst (rst), .clr (fill_clr), .inc (fill_inc), .at_last (fill_last)
  );

  lnk_run_cnt #(.LIMIT(CHK_GOOD)) i_good_run (
    .clk (clk), .rst (rst), .clr (ok_clr), .inc (ok_inc), .at_last (ok_last)
  );

  lnk_run_cnt #(.LIMIT(CHK_BAD)) i_bad_tally (
    .clk (clk), .rst (rst), .clr (err_clr), .inc (err_inc), .at_last (err_last)
  );

  assign good = (kind == WK_FILL) || (kind == WK_PAYLOAD);
  assign bad  = (kind == WK_BAD);

  always_comb begin
    nxt      = st;
    fill_inc = 1'b0;
    fill_clr = 1'b0;
    ok_inc   = 1'b0;
    ok_clr   = 1'b0;
    err_inc  = 1'b0;
    err_clr  = 1'b0;
    unique case (st)
      ST_ACQ: begin
        if (kind == WK_FILL) begin
          if (fill_last) begin
            nxt      = ST_SYNC;
            fill_clr = 1'b1;
          end else begin
            fill_inc = 1'b1;
          end
        end else if (kind == WK_PAYLOAD) begin
          nxt      = ST_SYNC;
          fill_clr = 1'b1;
        end else if (bad) begin
          fill_clr = 1'b1;
        end
      end
      ST_SYNC: begin
        if (bad) begin
          nxt     = ST_CHECK;
          ok_clr  = 1'b1;
          err_clr = 1'b1;
        end
      end
      ST_CHECK: begin
        if (good) begin
          if (ok_last) begin
            nxt     = ST_SYNC;
            ok_clr  = 1'b1;
            err_clr = 1'b1;
          end else begin
            ok_inc = 1'b1;
          end
        end else if (bad) begin
          ok_clr = 1'b1;
          if (err_last) begin
            nxt     = ST_ACQ;
            err_clr = 1'b1;
          end else begin
            err_inc = 1'b1;
          end
        end
      end
      default: nxt = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_ACQ;
      link_up   <= 1'b0;
      align_en  <= 1'b1;
      rx_valid  <= 1'b0;
      sync_lost <= 1'b0;
    end else begin
      st        <= nxt;
      link_up   <= (nxt != ST_ACQ);
      align_en  <= (nxt == ST_ACQ);
      rx_valid  <= good && (nxt != ST_ACQ);
      sync_lost <= (st != ST_ACQ) && (nxt == ST_ACQ);
    end
  end

  a_r3_payload_locks: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACQ && kind == WK_PAYLOAD) |=> link_up);

  a_r4_bad_keeps_acq: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACQ && kind == WK_BAD) |=> (!link_up && align_en));

  a_r5_sync_to_check: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SYNC && kind == WK_BAD) |=> (st == ST_CHECK && link_up && !align_en));

  a_r8_align_vs_link: assert property (@(posedge clk) disable iff (rst)
    align_en != link_up);

  a_r8_lost_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sync_lost |=> !sync_lost);

  a_r9_valid_needs_link: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> link_up);

  a_r11_no_word_holds: assert property (@(posedge clk) disable iff (rst)
    (kind == WK_NONE) |=> ($stable(st) && !rx_valid && !sync_lost));

endmodule

// File: tb/test_link_sync_ctrl.sv
module test_link_sync_ctrl;

  localparam time CLK_PER = 8ns;
  localparam int  NV      = 37;

  // class encodings {bad, eprop, data, cext, idle}
  localparam logic [4:0] N = 5'b00000;
  localparam logic [4:0] I = 5'b00001;
  localparam logic [4:0] C = 5'b00010;
  localparam logic [4:0] D = 5'b00100;
  localparam logic [4:0] E = 5'b01000;
  localparam logic [4:0] B = 5'b10000;

  // entry: {class[4:0], expected {link_up, align_en, rx_valid, sync_lost}, requirement}
  localparam logic [12:0] VEC [NV] = '{
    {I, 4'h4, 4'd2}, {C, 4'h4, 4'd2}, {I, 4'hA, 4'd2}, {D, 4'hA, 4'd9},
    {B, 4'h8, 4'd5}, {D, 4'hA, 4'd6}, {I, 4'hA, 4'd6}, {B, 4'h8, 4'd7},
    {D, 4'hA, 4'd7}, {D, 4'hA, 4'd7}, {D, 4'hA, 4'd7}, {B, 4'h8, 4'd7},
    {C, 4'hA, 4'd7}, {B, 4'h5, 4'd8}, {I, 4'h4, 4'd4}, {I, 4'h4, 4'd4},
    {B, 4'h4, 4'd4}, {I, 4'h4, 4'd4}, {I, 4'h4, 4'd4}, {N, 4'h4, 4'd11},
    {I, 4'hA, 4'd11}, {B, 4'h8, 4'd5}, {D, 4'hA, 4'd6}, {D, 4'hA, 4'd6},
    {E, 4'hA, 4'd6}, {I, 4'hA, 4'd6}, {B, 4'h8, 4'd6}, {B, 4'h8, 4'd6},
    {B, 4'h8, 4'd6}, {D | I, 4'h5, 4'd10}, {N, 4'h4, 4'd8}, {E, 4'hA, 4'd3},
    {B, 4'h8, 4'd5}, {B, 4'h8, 4'd7}, {B, 4'h8, 4'd7}, {B, 4'h5, 4'd8},
    {D, 4'hA, 4'd3}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] cls = '0;
  logic       link_up, align_en, rx_valid, sync_lost;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;

  link_sync_ctrl i_link_sync_ctrl (
    .clk        (clk),
    .rst        (rst),
    .word_idle  (cls[0]),
    .word_cext  (cls[1]),
    .word_data  (cls[2]),
    .word_eprop (cls[3]),
    .word_bad   (cls[4]),
    .link_up    (link_up),
    .align_en   (align_en),
    .rx_valid   (rx_valid),
    .sync_lost  (sync_lost)
  );

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {link_up, align_en, rx_valid, sync_lost};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: {link_up,align_en,rx_valid,sync_lost} actual %b expected %b",
               req, act, exp);
    end
  endtask

  // present one word, sample 1 ns after the edge that evaluates it
  task automatic apply(input logic [4:0] v);
    @(negedge clk);
    cls = v;
    @(posedge clk);
    #1ns;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1ns;
    chk("R1", 4'h4);  // reset state

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][12:8]);
      chk(tag(VEC[k][3:0]), VEC[k][7:4]);
    end

    // R1: reset while synchronized, with a data word present
    @(negedge clk);
    rst = 1'b1;
    cls = D;
    @(posedge clk);
    #1ns;
    chk("R1", 4'h4);
    @(negedge clk);
    rst = 1'b0;
    cls = N;
    @(posedge clk);
    #1ns;
    chk("R1", 4'h4);

    // R10: simultaneous idle and carrier extend breaks the fill run
    apply(I);     chk("R10", 4'h4);
    apply(I);     chk("R10", 4'h4);
    apply(I | C); chk("R10", 4'h4);
    apply(I);     chk("R10", 4'h4);
    apply(I);     chk("R10", 4'h4);
    apply(I);     chk("R10", 4'hA);

    @(negedge clk);
    cls = N;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule